// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block watches the two wires of an I2C bus, the clock line and the data line, and turns them into clean, single-clock-cycle events for a slave state machine. Both wires are sampled by the fast system clock and never used as clocks. Each wire passes through a two-stage synchronizer and then a counter-based deglitch filter. The filter suppresses the multiple threshold crossings that a slow, noisy bus edge can produce.

From the filtered levels the block produces START and STOP pulses and rising and falling edge strobes for the bus clock. It also outputs the filtered levels themselves. The two condition detectors are built the same way from the old and new filtered data level. Neither one resets or gates the other, so each pulse can serve directly as a one-shot reset for the address and data registers of a slave. A short settle window after reset keeps the outputs quiet until the filters carry real bus values. At a system clock of tens of MHz, the default filter length adds well under a microsecond of delay, which is small against a 100 kHz standard-mode bit period.

Top module: `bus_cond_detect`

## Requirements
- R1: While reset is asserted, scl_f and sda_f read high (idle bus) and start_pulse, stop_pulse, scl_rise and scl_fall read low, whatever the raw inputs are.
- R2: A raw level that changes before clock edge n and then holds appears on the matching filtered output right after edge n+FILT_CYCLES+1 (two synchronizer edges, then FILT_CYCLES filter samples).
- R3: A raw level held for fewer than FILT_CYCLES consecutive samples leaves the filtered output unchanged; a return to the old level restarts the count from zero.
- R4: START or STOP is reported only when filtered SCL was high both in the cycle where filtered SDA changed and in the cycle before it; SCL and SDA changing in the same cycle produce no condition.
- R5: START: when filtered SDA goes from 1 to 0 with the SCL condition of R4, start_pulse is high for exactly one cycle, the cycle after filtered SDA reads 0.
- R6: STOP: when filtered SDA goes from 0 to 1 with the SCL condition of R4, stop_pulse is high for exactly one cycle, the cycle after filtered SDA reads 1.
- R7: scl_rise (scl_fall) is high for exactly one cycle, the cycle after filtered SCL reads 1 (0) following a 0 (1); the two are never high together.
- R8: For the first FILT_CYCLES+3 clock edges after reset release, none of the four strobes is asserted, even if a raw input was low during reset.
- R9: Any SDA activity while filtered SCL is low produces neither START nor STOP.
- R10: The START and STOP detectors are independent: a START followed by a STOP shortly after reports one pulse of each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| start_pulse | output | 1 | One-cycle START condition strobe |
| stop_pulse | output | 1 | One-cycle STOP condition strobe |
| scl_f | output | 1 | Filtered bus clock level |
| sda_f | output | 1 | Filtered bus data level |
| scl_rise | output | 1 | One-cycle strobe on filtered SCL rising |
| scl_fall | output | 1 | One-cycle strobe on filtered SCL falling |

## Verification
Directed sequences check the exact filter latency and separate clean START and STOP edges from SDA toggles under a low clock. They also cover glitches one sample short of the filter length, glitches interrupted and then restarted, and SCL and SDA changing in the same cycle, which a detector without the previous-SCL term would misreport. A bus held with SDA low through reset shows that the settle window keeps the filter's first transition from posing as a START. Long random runs with mixed glitch and hold lengths are compared cycle by cycle against a model that decides each filter transition from a history of raw samples, so that latency, pulse width and ordering faults all show up.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int LANE_SCL  = 0;
    localparam int LANE_SDA  = 1;
    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic meta;
        logic stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = din;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: RST_VAL, stable: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stable;
endmodule

// File: rtl/bcd_filter.sv
module bcd_filter #(
    parameter int   FILT_CYCLES = 4,
    parameter logic RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.lvl = din;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: RST_VAL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.lvl;
endmodule

// File: rtl/bcd_events.sv
module bcd_events
    import bcd_pkg::*;
#(
    parameter int SETTLE_CYCLES = 7
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_lvl,
    input  logic     sda_lvl,
    output bus_evt_t evt
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SETTLE_END = SW'(SETTLE_CYCLES);

    typedef struct packed {
        logic          scl_p;
        logic          sda_p;
        logic [SW-1:0] settle;
        bus_evt_t      ev;
    } ev_st_t;

    ev_st_t st_d, st_q;
    logic   armed;
    logic   scl_steady;

    always_comb begin
        st_d       = st_q;
        armed      = (st_q.settle == SETTLE_END);
        scl_steady = scl_lvl & st_q.scl_p;

        st_d.ev.start = armed & scl_steady &  st_q.sda_p & ~sda_lvl;
        st_d.ev.stop  = armed & scl_steady & ~st_q.sda_p &  sda_lvl;
        st_d.ev.rise  = armed &  scl_lvl & ~st_q.scl_p;
        st_d.ev.fall  = armed & ~scl_lvl &  st_q.scl_p;

        st_d.scl_p = scl_lvl;
        st_d.sda_p = sda_lvl;
        if (!armed) begin
            st_d.settle = st_q.settle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl_p: 1'b1, sda_p: 1'b1, settle: '0, ev: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt = st_q.ev;
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
    import bcd_pkg::*;
#(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_pulse,
    output logic stop_pulse,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall
);
    localparam int SETTLE_CYCLES = FILT_CYCLES + 3;

    logic [NUM_LANES-1:0] raw;
    logic [NUM_LANES-1:0] synced;
    logic [NUM_LANES-1:0] filt;
    bus_evt_t             evt;

    assign raw[LANE_SCL] = scl_in;
    assign raw[LANE_SDA] = sda_in;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        bcd_sync #(
            .RST_VAL (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[g]),
            .dout  (synced[g])
        );

        bcd_filter #(
            .FILT_CYCLES (FILT_CYCLES),
            .RST_VAL     (1'b1)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (synced[g]),
            .dout  (filt[g])
        );
    end

    bcd_events #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (filt[LANE_SCL]),
        .sda_lvl (filt[LANE_SDA]),
        .evt     (evt)
    );

    assign scl_f       = filt[LANE_SCL];
    assign sda_f       = filt[LANE_SDA];
    assign start_pulse = evt.start;
    assign stop_pulse  = evt.stop;
    assign scl_rise    = evt.rise;
    assign scl_fall    = evt.fall;
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker #(
    parameter int FILT_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start_pulse,
    input logic stop_pulse,
    input logic scl_f,
    input logic sda_f,
    input logic scl_rise,
    input logic scl_fall
);
    localparam int SETTLE = FILT_CYCLES + 3;
    localparam int KW     = $clog2(SETTLE + 2);
    localparam logic [KW-1:0] KMAX = KW'(SETTLE + 1);

    logic [KW-1:0] edges_q;
    logic          any_evt;

    assign any_evt = start_pulse | stop_pulse | scl_rise | scl_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_q <= '0;
        end else if (edges_q != KMAX) begin
            edges_q <= edges_q + 1'b1;
        end
    end

    AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R5

    AST_STOP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse); // R6

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ($past(sda_f, 2) && !$past(sda_f) && $past(scl_f) && $past(scl_f, 2))); // R4

    AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (!$past(sda_f, 2) && $past(sda_f) && $past(scl_f) && $past(scl_f, 2))); // R9

    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> ($past(scl_f) && !$past(scl_f, 2))); // R7

    AST_RISE_FALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall)); // R7

    AST_QUIET_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q <= KW'(SETTLE)) |-> !any_evt); // R8

    if (FILT_CYCLES > 1) begin : g_hold
        AST_SDA_NO_CHATTER: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(sda_f) |=> $stable(sda_f)); // R3
    end
endmodule

bind bus_cond_detect bcd_checker #(
    .FILT_CYCLES (FILT_CYCLES)
) u_bcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .scl_f       (scl_f),
    .sda_f       (sda_f),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall)
);

// File: tb/bus_cond_detect_bench.sv
module bus_cond_detect_bench;
    localparam int FC     = 4;
    localparam int SETTLE = FC + 3;
    localparam int HL     = FC + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b0;
    logic start_pulse, stop_pulse, scl_f, sda_f, scl_rise, scl_fall;

    always #4 clk = ~clk;

    bus_cond_detect #(.FILT_CYCLES(FC)) u_bus_cond_detect (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .scl_f(scl_f), .sda_f(sda_f), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference: raw sample history, newest at index 0.
    logic [HL-1:0] h_scl, h_sda;
    logic m_sclf, m_sdaf, m_sclp, m_sdap, m_start, m_stop, m_rise, m_fall, m_armed;
    int   m_sc;

    // Filtered level flips once the last FC synchronized samples all differ.
    function automatic logic filt_next(input logic cur, input logic [HL-1:0] h);
        for (int k = 2; k < HL; k++) begin
            if (h[k] == cur) return cur;
        end
        return ~cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_scl = '1; h_sda = '1;
            m_sclf = 1'b1; m_sdaf = 1'b1; m_sclp = 1'b1; m_sdap = 1'b1;
            m_start = 1'b0; m_stop = 1'b0; m_rise = 1'b0; m_fall = 1'b0;
            m_sc = 0;
        end else begin
            h_scl   = {h_scl[HL-2:0], scl_in};
            h_sda   = {h_sda[HL-2:0], sda_in};
            m_armed = (m_sc == SETTLE);
            m_start = m_armed && m_sclf && m_sclp &&  m_sdap && !m_sdaf;
            m_stop  = m_armed && m_sclf && m_sclp && !m_sdap &&  m_sdaf;
            m_rise  = m_armed &&  m_sclf && !m_sclp;
            m_fall  = m_armed && !m_sclf &&  m_sclp;
            m_sclp  = m_sclf;
            m_sdap  = m_sdaf;
            m_sclf  = filt_next(m_sclf, h_scl);
            m_sdaf  = filt_next(m_sdaf, h_sda);
            if (m_sc < SETTLE) m_sc++;
        end
    end

    // Observation state
    int  c_start, c_stop, c_rise, c_fall, c_wide, c_sda_low;
    logic o_start_prev, o_stop_prev;

    task automatic clear_counts();
        c_start = 0; c_stop = 0; c_rise = 0; c_fall = 0; c_wide = 0; c_sda_low = 0;
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic compare_model();
        bit ok;
        ok = (start_pulse == m_start) && (stop_pulse == m_stop) && (scl_f == m_sclf) &&
             (sda_f == m_sdaf) && (scl_rise == m_rise) && (scl_fall == m_fall);
        n_tests++;
        if (!ok) begin
            n_fail++;
            if (start_pulse != m_start) $display("FAIL R5 start_pulse actual=%0b expected=%0b", start_pulse, m_start);
            if (stop_pulse  != m_stop)  $display("FAIL R6 stop_pulse actual=%0b expected=%0b", stop_pulse, m_stop);
            if (scl_f != m_sclf)        $display("FAIL R2 scl_f actual=%0b expected=%0b", scl_f, m_sclf);
            if (sda_f != m_sdaf)        $display("FAIL R3 sda_f actual=%0b expected=%0b", sda_f, m_sdaf);
            if (scl_rise != m_rise)     $display("FAIL R7 scl_rise actual=%0b expected=%0b", scl_rise, m_rise);
            if (scl_fall != m_fall)     $display("FAIL R7 scl_fall actual=%0b expected=%0b", scl_fall, m_fall);
        end
    endtask

    // Sample at the falling edge, then drive the next input values.
    task automatic tick(input logic s, input logic d);
        @(negedge clk);
        compare_model();
        if (start_pulse) c_start++;
        if (stop_pulse)  c_stop++;
        if (scl_rise)    c_rise++;
        if (scl_fall)    c_fall++;
        if (!sda_f)      c_sda_low++;
        if ((start_pulse && o_start_prev) || (stop_pulse && o_stop_prev)) c_wide++;
        o_start_prev = start_pulse;
        o_stop_prev  = stop_pulse;
        scl_in = s;
        sda_in = d;
    endtask

    task automatic hold(input logic s, input logic d, input int n);
        for (int i = 0; i < n; i++) tick(s, d);
    endtask

    initial begin
        int lat;
        void'($urandom(32'd20240611));
        o_start_prev = 1'b0; o_stop_prev = 1'b0;
        clear_counts();

        // R1: reset state with SDA held low on the wire
        repeat (3) @(negedge clk);
        chk(scl_f === 1'b1 && sda_f === 1'b1, "R1 filtered levels in reset", {scl_f, sda_f}, 3);
        chk({start_pulse, stop_pulse, scl_rise, scl_fall} === 4'b0000, "R1 strobes in reset",
            {start_pulse, stop_pulse, scl_rise, scl_fall}, 0);
        rst_n = 1'b1;

        // R8: filter settles on low SDA without a START
        clear_counts();
        hold(1, 0, 20);
        chk(c_start + c_stop + c_rise + c_fall == 0, "R8 strobes during settle", c_start + c_stop + c_rise + c_fall, 0);
        chk(sda_f == 1'b0, "R8 sda_f settled low", sda_f, 0);

        // R6: SDA rises with SCL high
        clear_counts();
        hold(1, 1, 12);
        chk(c_stop == 1, "R6 stop count", c_stop, 1);

        // R2 and R5: exact latency and one START
        clear_counts();
        tick(1, 0);
        lat = 0;
        for (int j = 1; j <= FC + 6; j++) begin
            tick(1, 0);
            if (lat == 0 && !sda_f) lat = j;
        end
        chk(lat == FC + 2, "R2 filter latency in edges", lat, FC + 2);
        chk(c_start == 1 && c_wide == 0, "R5 single one-cycle start", c_start, 1);

        // R3: glitch one sample short
        hold(1, 1, 12);
        clear_counts();
        hold(1, 0, FC - 1);
        hold(1, 1, 12);
        chk(c_sda_low == 0, "R3 short glitch reached sda_f", c_sda_low, 0);
        chk(c_start + c_stop == 0, "R3 short glitch conditions", c_start + c_stop, 0);

        // R3: interrupted glitch restarts the count
        clear_counts();
        hold(1, 0, FC - 1);
        hold(1, 1, 1);
        hold(1, 0, FC - 1);
        hold(1, 1, 12);
        chk(c_sda_low == 0, "R3 restarted count", c_sda_low, 0);

        // R9 and R7: SDA toggles under a low clock
        clear_counts();
        hold(0, 1, 10);
        hold(0, 0, 10);
        hold(0, 1, 10);
        hold(1, 1, 12);
        chk(c_start + c_stop == 0, "R9 conditions with SCL low", c_start + c_stop, 0);
        chk(c_rise == 1 && c_fall == 1, "R7 one rise and one fall", c_rise * 10 + c_fall, 11);

        // R4: SCL rises in the same cycle SDA falls
        hold(0, 1, 10);
        clear_counts();
        hold(1, 0, 12);
        chk(c_start == 0, "R4 simultaneous change gives no start", c_start, 0);
        chk(c_rise == 1, "R7 rise with simultaneous change", c_rise, 1);
        hold(1, 1, 12);

        // R10: START then STOP in quick succession
        clear_counts();
        hold(1, 0, FC + 2);
        hold(1, 1, 12);
        chk(c_start == 1 && c_stop == 1, "R10 start then stop", c_start * 10 + c_stop, 11);
        chk(c_wide == 0, "R5 R6 pulse width", c_wide, 0);

        // Random runs: glitches and holds of varied length, checked against the model
        for (int r = 0; r < 600; r++) begin
            logic s, d;
            int   len;
            s   = 1'($urandom);
            d   = 1'($urandom);
            len = 1 + int'($urandom % (2 * FC + 3));
            hold(s, d, len);
        end
        hold(1, 1, 20);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1-scope run hung actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule